// File: doc/BRIEF.md
# Audio Transmit FIFO and Interrupt Front End

This block sits between a 32-bit memory-mapped register port and the serializer of an audio serial output. Software writes sample words into a deep FIFO through a data port, two words per stereo frame (left first, then right). The serializer drains the FIFO one word at a time through a show-ahead read port and takes its clock ratio, sample resolution, channel and framing settings from the configuration register outputs.

Two FIFO conditions are watched: the FIFO being empty (underrun) and its occupancy being below a programmable trigger threshold. The threshold is the FIFO depth shifted right by a 4-bit level field, so each step halves it. Each condition is latched into a status bit while it holds. A bit is cleared by writing 1 to it and sets again on the next cycle if its condition persists. A mask register and a global interrupt enable reduce the status bits to one interrupt line.

Top module: `audio_tx_fifo`

## Requirements
- R1: After reset the config register and the mask register read 0, irq is 0, ser_valid is 0, and the version register (offset 0x00) reads the VERSION parameter.
- R2: The config register (offset 0x04) stores only its defined fields and reads 0 in bits 7:3 and 23:22. The fields are: bit 0 transmit enable, bit 1 interrupt enable, bit 2 left flag, bits 15:8 clock ratio, bits 21:16 resolution, bits 27:24 trigger level and bits 31:28 channel. The config outputs follow the stored fields.
- R3: A write to the data port at offset 0x10 pushes wdata into the FIFO. Words come out at ser_word in write order. ser_valid is 1 while the FIFO holds a word, and ser_pop removes the current word.
- R4: The FIFO holds exactly DEPTH words. A data-port write while the FIFO is full is dropped.
- R5: Writes to offsets 0x14, 0x18 and 0x1C push nothing. A write to the version register leaves it unchanged.
- R6: Status bit 0 (underrun) is set on the clock edge after any cycle in which the FIFO is empty.
- R7: Status bit 1 (level) is set on the clock edge after any cycle in which the occupancy is below DEPTH >> level. It is not set while the occupancy equals the threshold.
- R8: Writing the status register (offset 0x0C) clears each bit written as 1 and leaves bits written as 0 unchanged. A cleared bit whose condition still holds reads 1 again one cycle later. Status bits stay set after their condition ends until they are cleared.
- R9: irq is 1 exactly when the interrupt enable is 1 and some status bit is 1 with its mask bit (offset 0x08) also 1.
- R10: The mask register stores only bits 1:0. The data ports read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Byte address of the register access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Combinational read data for addr |
| ser_pop | input | 1 | Serializer takes the current word |
| ser_valid | output | 1 | FIFO holds at least one word |
| ser_word | output | 32 | Oldest word in the FIFO |
| cfg_tx_en | output | 1 | Transmit enable field |
| cfg_left | output | 1 | Left flag field |
| cfg_ratio | output | 8 | Clock ratio field |
| cfg_res | output | 6 | Sample resolution field |
| cfg_chan | output | 4 | Channel field |
| irq | output | 1 | Interrupt request |

## Verification
A corrupted occupancy count shows up within one cycle as a wrong level or underrun bit in the status register, so the bench checks the threshold edge at occupancy equal to the threshold and one word below it. A pointer fault shows up as an out-of-order or repeated ser_word, or as a full FIFO accepting a word. Filling to DEPTH and draining word by word exposes these on the next pop. A stale status latch shows up as an irq that stays asserted after a write-one-clear while its condition is gone.

// File: rtl/atf_pkg.sv
// Package: shared register offsets and config field positions for the
// audio transmit FIFO. Assumes 32-bit registers on a 4-byte stride.
package atf_pkg;
    localparam int REG_IDX_W = 3;

    localparam logic [REG_IDX_W-1:0] IDX_VERSION = 3'd0;
    localparam logic [REG_IDX_W-1:0] IDX_CONFIG  = 3'd1;
    localparam logic [REG_IDX_W-1:0] IDX_MASK    = 3'd2;
    localparam logic [REG_IDX_W-1:0] IDX_STATUS  = 3'd3;
    localparam logic [REG_IDX_W-1:0] IDX_DATA0   = 3'd4;

    localparam int CFG_TXEN_BIT  = 0;
    localparam int CFG_IE_BIT    = 1;
    localparam int CFG_LEFT_BIT  = 2;
    localparam int CFG_RATIO_LSB = 8;
    localparam int CFG_RES_LSB   = 16;
    localparam int CFG_LVL_LSB   = 24;
    localparam int CFG_CHAN_LSB  = 28;

    localparam logic [31:0] CFG_WMASK = 32'hFF3F_FF07;

    localparam int N_SRC = 2;
    localparam int SRC_UNDERRUN = 0;
    localparam int SRC_LEVEL    = 1;
endpackage

// File: rtl/atf_fifo.sv
// Module: sample FIFO with show-ahead read. Pushes while full and pops while
// empty are ignored. Assumes DEPTH is a power of two.
module atf_fifo #(
    parameter int DEPTH = 1024,
    parameter int WIDTH = 32,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = AW + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic [CW-1:0]    count,
    output logic             full,
    output logic             empty
);
    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr, rd_ptr;
    logic             do_push, do_pop;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rd_ptr];

    // storage write, no reset on the array
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_data;
    end

    // pointer and occupancy tracking
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/atf_irq.sv
// Module: threshold compare, sticky status with write-one-clear, and the
// masked interrupt output. Assumes count never exceeds DEPTH.
module atf_irq #(
    parameter int DEPTH = 1024,
    localparam int CW = $clog2(DEPTH) + 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [CW-1:0]             count,
    input  logic [3:0]                level_sel,
    input  logic                      clr_en,
    input  logic [atf_pkg::N_SRC-1:0] clr_bits,
    input  logic [atf_pkg::N_SRC-1:0] mask,
    input  logic                      int_en,
    output logic [atf_pkg::N_SRC-1:0] status,
    output logic                      irq
);
    import atf_pkg::*;

    logic [CW-1:0]    threshold;
    logic [N_SRC-1:0] cond;
    logic [N_SRC-1:0] clr_vec;

    // trigger threshold halves with each level step
    always_comb begin
        threshold           = CW'(DEPTH) >> level_sel;
        cond                = '0;
        cond[SRC_UNDERRUN]  = (count == '0);
        cond[SRC_LEVEL]     = (count < threshold);
        clr_vec             = clr_en ? clr_bits : '0;
    end

    // latch live conditions, clear by write-one
    always_ff @(posedge clk) begin
        if (!rst_n) status <= '0;
        else        status <= (status | cond) & ~clr_vec;
    end

    assign irq = int_en && |(status & mask);
endmodule

// File: rtl/audio_tx_fifo.sv
// Module: top of the audio transmit FIFO front end. Decodes the register
// port, holds config and mask, feeds the FIFO and the interrupt logic.
// Assumes aligned word accesses; address bits 1:0 are ignored.
module audio_tx_fifo #(
    parameter int          DEPTH   = 1024,
    parameter int          ADDR_W  = 5,
    parameter logic [31:0] VERSION = 32'h0002_0100,
    localparam int CW = $clog2(DEPTH) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    input  logic              ser_pop,
    output logic              ser_valid,
    output logic [31:0]       ser_word,
    output logic              cfg_tx_en,
    output logic              cfg_left,
    output logic [7:0]        cfg_ratio,
    output logic [5:0]        cfg_res,
    output logic [3:0]        cfg_chan,
    output logic              irq
);
    import atf_pkg::*;

    logic [31:0]          cfg_q;
    logic [N_SRC-1:0]     mask_q;
    logic [N_SRC-1:0]     stat_q;
    logic [REG_IDX_W-1:0] idx;
    logic                 wr_cfg, wr_mask, wr_stat, wr_data0;
    logic [CW-1:0]        fifo_count;
    logic                 fifo_full, fifo_empty;

    assign idx      = addr[REG_IDX_W+1:2];
    assign wr_cfg   = wr_en && (idx == IDX_CONFIG);
    assign wr_mask  = wr_en && (idx == IDX_MASK);
    assign wr_stat  = wr_en && (idx == IDX_STATUS);
    assign wr_data0 = wr_en && (idx == IDX_DATA0);

    // config and mask registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q  <= '0;
            mask_q <= '0;
        end else begin
            if (wr_cfg)  cfg_q  <= wdata & CFG_WMASK;
            if (wr_mask) mask_q <= wdata[N_SRC-1:0];
        end
    end

    // read mux; data ports and unused offsets read zero
    always_comb begin
        case (idx)
            IDX_VERSION: rdata = VERSION;
            IDX_CONFIG:  rdata = cfg_q;
            IDX_MASK:    rdata = {{(32-N_SRC){1'b0}}, mask_q};
            IDX_STATUS:  rdata = {{(32-N_SRC){1'b0}}, stat_q};
            default:     rdata = '0;
        endcase
    end

    assign cfg_tx_en = cfg_q[CFG_TXEN_BIT];
    assign cfg_left  = cfg_q[CFG_LEFT_BIT];
    assign cfg_ratio = cfg_q[CFG_RATIO_LSB +: 8];
    assign cfg_res   = cfg_q[CFG_RES_LSB +: 6];
    assign cfg_chan  = cfg_q[CFG_CHAN_LSB +: 4];
    assign ser_valid = !fifo_empty;

    atf_fifo #(.DEPTH(DEPTH), .WIDTH(32)) fifo_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (wr_data0),
        .push_data (wdata),
        .pop       (ser_pop),
        .head      (ser_word),
        .count     (fifo_count),
        .full      (fifo_full),
        .empty     (fifo_empty)
    );

    atf_irq #(.DEPTH(DEPTH)) irq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .count     (fifo_count),
        .level_sel (cfg_q[CFG_LVL_LSB +: 4]),
        .clr_en    (wr_stat),
        .clr_bits  (wdata[N_SRC-1:0]),
        .mask      (mask_q),
        .int_en    (cfg_q[CFG_IE_BIT]),
        .status    (stat_q),
        .irq       (irq)
    );
endmodule

// File: rtl/atf_checker.sv
// Module: assertion checker for the audio transmit FIFO, bound to the top.
// Assumes it sees the FIFO occupancy and status latch of the bound instance.
module atf_checker #(
    parameter int DEPTH = 1024,
    parameter int ADDR_W = 5,
    localparam int CW = $clog2(DEPTH) + 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [31:0]       wdata,
    input logic [CW-1:0]     count,
    input logic [1:0]        status,
    input logic              int_en,
    input logic              irq,
    input logic              ser_valid,
    input logic              ser_pop,
    input logic [31:0]       ser_word
);
    logic stat_wr;
    assign stat_wr = wr_en && (addr[4:2] == 3'd3);

    // occupancy never exceeds the depth
    p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));

    // a full FIFO without a pop stays full: pushes are dropped
    p_full_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (count == CW'(DEPTH) && !ser_pop) |=> (count == CW'(DEPTH)));

    // head word holds while nothing is popped
    p_head_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_valid && !ser_pop) |=> $stable(ser_word));

    // empty FIFO latches underrun unless that bit is being cleared
    p_underrun_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (count == '0 && !(stat_wr && wdata[0])) |=> status[0]);

    // write-one clears the level bit
    p_w1c_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_wr && wdata[1]) |=> !status[1]);

    // no interrupt while the global enable is off
    p_irq_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !int_en |-> !irq);
endmodule

bind audio_tx_fifo atf_checker #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .addr      (addr),
    .wdata     (wdata),
    .count     (fifo_count),
    .status    (stat_q),
    .int_en    (cfg_q[1]),
    .irq       (irq),
    .ser_valid (ser_valid),
    .ser_pop   (ser_pop),
    .ser_word  (ser_word)
);

// File: tb/audio_tx_fifo_tb_top.sv
// Bench: table-driven register checks, then directed FIFO, status and irq tests.
module audio_tx_fifo_tb_top;
    localparam int          DEPTH = 64;
    localparam logic [31:0] VER   = 32'h0002_0100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [4:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        ser_pop = 1'b0;
    logic        ser_valid;
    logic [31:0] ser_word;
    logic        cfg_tx_en, cfg_left, irq;
    logic [7:0]  cfg_ratio;
    logic [5:0]  cfg_res;
    logic [3:0]  cfg_chan;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    audio_tx_fifo #(.DEPTH(DEPTH), .ADDR_W(5), .VERSION(VER)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .ser_pop(ser_pop), .ser_valid(ser_valid),
        .ser_word(ser_word), .cfg_tx_en(cfg_tx_en), .cfg_left(cfg_left),
        .cfg_ratio(cfg_ratio), .cfg_res(cfg_res), .cfg_chan(cfg_chan),
        .irq(irq)
    );

    // {write offset, write data, read offset, expected read}
    localparam logic [79:0] VECS [6] = '{
        {8'h04, 32'hFFFF_FFFF, 8'h04, 32'hFF3F_FF07},
        {8'h04, 32'h1234_5678, 8'h04, 32'h1234_5600},
        {8'h04, 32'hA5C3_1E06, 8'h04, 32'hA503_1E06},
        {8'h08, 32'hFFFF_FFFF, 8'h08, 32'h0000_0003},
        {8'h08, 32'h0000_0002, 8'h08, 32'h0000_0002},
        {8'h04, 32'h0000_0000, 8'h04, 32'h0000_0000}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic pop1();
        @(negedge clk);
        ser_pop = 1'b1;
        @(posedge clk);
        @(negedge clk);
        ser_pop = 1'b0;
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd(5'h04, v); chk("R1 config", v, 32'h0);
        rd(5'h08, v); chk("R1 mask", v, 32'h0);
        rd(5'h00, v); chk("R1 version", v, VER);
        chk("R1 irq", {31'b0, irq}, 32'h0);
        chk("R1 ser_valid", {31'b0, ser_valid}, 32'h0);
        // R6 R7 empty FIFO latches both bits one cycle later
        tick();
        rd(5'h0C, v); chk("R6 R7 status after reset", v, 32'h3);

        // R2 R10 table of register writes and readbacks
        for (int i = 0; i < 6; i++) begin
            wr(VECS[i][76:72], VECS[i][71:40]);
            rd(VECS[i][36:32], v);
            chk("R2 R10 table readback", v, VECS[i][31:0]);
            if (i == 2) begin
                chk("R2 cfg fields", {cfg_chan, cfg_res, cfg_ratio, 6'b0, cfg_left, cfg_tx_en},
                    {4'hA, 6'h03, 8'h1E, 6'b0, 1'b1, 1'b0});
            end
        end

        // R8 write-one-clear and re-assert
        wr(5'h0C, 32'h3);
        rd(5'h0C, v); chk("R8 cleared", v, 32'h0);
        tick();
        rd(5'h0C, v); chk("R8 reassert", v, 32'h3);
        wr(5'h0C, 32'h1);
        rd(5'h0C, v); chk("R8 partial clear", v, 32'h2);

        // R3 R7 fill to 40 words with level 1 (threshold DEPTH/2 = 32)
        wr(5'h04, 32'h0100_0000);
        for (int i = 0; i < 40; i++) wr(5'h10, 32'hA000_0000 + i);
        chk("R3 ser_valid", {31'b0, ser_valid}, 32'h1);
        wr(5'h0C, 32'h3);
        tick();
        rd(5'h0C, v); chk("R7 above threshold", v, 32'h0);
        for (int i = 0; i < 8; i++) begin
            chk("R3 order", ser_word, 32'hA000_0000 + i);
            pop1();
        end
        tick();
        rd(5'h0C, v); chk("R7 at threshold not set", v, 32'h0);
        chk("R3 order", ser_word, 32'hA000_0008);
        pop1();
        rd(5'h0C, v); chk("R7 not yet latched", v, 32'h0);
        tick();
        rd(5'h0C, v); chk("R7 below threshold", v, 32'h2);

        // R9 interrupt gating
        wr(5'h08, 32'h2);
        wr(5'h04, 32'h0100_0002);
        chk("R9 irq level masked in", {31'b0, irq}, 32'h1);
        wr(5'h08, 32'h1);
        chk("R9 irq masked out", {31'b0, irq}, 32'h0);
        wr(5'h08, 32'h3);
        chk("R9 irq mask both", {31'b0, irq}, 32'h1);
        wr(5'h04, 32'h0100_0000);
        chk("R9 irq global off", {31'b0, irq}, 32'h0);

        // R8 sticky: drain, then status stays after refill
        for (int i = 9; i < 40; i++) begin
            chk("R3 order", ser_word, 32'hA000_0000 + i);
            pop1();
        end
        chk("R3 empty", {31'b0, ser_valid}, 32'h0);
        tick();
        rd(5'h0C, v); chk("R6 underrun latched", v, 32'h3);

        // R4 fill to full plus one dropped word
        for (int i = 0; i < DEPTH; i++) wr(5'h10, 32'hB000_0000 + i);
        wr(5'h10, 32'hDEAD_BEEF);
        rd(5'h0C, v); chk("R8 sticky after refill", v, 32'h3);
        for (int i = 0; i < DEPTH; i++) begin
            chk("R4 full order", ser_word, 32'hB000_0000 + i);
            pop1();
        end
        chk("R4 dropped word absent", {31'b0, ser_valid}, 32'h0);

        // R5 other data ports and version are ignored
        wr(5'h14, 32'h1111_1111);
        wr(5'h18, 32'h2222_2222);
        wr(5'h1C, 32'h3333_3333);
        chk("R5 no push", {31'b0, ser_valid}, 32'h0);
        wr(5'h00, 32'h0);
        rd(5'h00, v); chk("R5 version", v, VER);
        rd(5'h10, v); chk("R10 data port reads 0", v, 32'h0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule